// File: doc/BRIEF.md
# GPIO Direction Control with Abort

This block owns the direction and output-value state of a bank of general-purpose pins. Software writes a direction word and an output-value word through a small register port and can read both back. Each pin's output enable is registered, so the pad control never glitches when the stored words change.

A separate abort input, which may arrive from any clock domain, pulls every output enable low. The pins then float and external resistors can hold them at a safe level. Writes made while the abort is active still land in the stored direction word, but they cannot turn a pin into a driver. When the abort goes away, the stored direction is applied again without any further write.

Top module: `gpioAbortDir`

## Requirements
- R1: While reset is asserted and right after it is released, every output enable, every output value and both readable registers are zero. All pins are inputs with no pull.
- R2: A write to address 0 stores the write data as the direction word (bit i set means pin i is an output). Read data shows the new value after the first rising edge.
- R3: With no abort, `pinOe` equals the direction word one edge after it is stored. A write at edge k shows at edge k+1, and the old value is still visible after edge k.
- R4: The abort input passes through two synchroniser flops and then the output-enable register. When `abortIn` rises, the enables still hold their old value after the second rising edge and are all zero after the third.
- R5: While the synchronised abort is high, writes to the direction word are stored and can be read back, but `pinOe` stays all zero on every cycle.
- R6: When `abortIn` falls, `pinOe` stays zero after the second rising edge. After the third it equals the stored direction word, with no write needed.
- R7: A write to address 1 stores the output-value word, which drives `pinOut` from the next edge on, whether or not the abort is active.
- R8: Read data is combinational on `regAddr`: address 0 returns the direction word, address 1 returns the output-value word, and addresses 2 and 3 return zero.
- R9: Writes to addresses 2 and 3 change neither stored word, and therefore change neither `pinOe` nor `pinOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 2 | Register address for writes and reads |
| regWrData | input | NUM_PINS | Write data |
| regRdData | output | NUM_PINS | Read data for `regAddr` |
| abortIn | input | 1 | Asynchronous I/O abort request, active high |
| pinOut | output | NUM_PINS | Output value per pin |
| pinOe | output | NUM_PINS | Registered output enable per pin |

## Verification
The risky coincidence is a direction write that lands on the same edge where the synchronised abort rises. The direction register and the abort view then change together, and a wrong ordering would let the new outputs drive for one cycle. The bench provokes this by raising `abortIn` one edge before a write that sets every direction bit, so that the write is captured on the second synchroniser edge. It samples `pinOe` on every following cycle and requires that no newly written bit ever appears. It then releases the abort and requires the full stored word to come back exactly three edges later.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic abortSync;
  } ctlStrobes_t;

endpackage

// File: rtl/gpioDirCtrl.sv
module gpioDirCtrl
  import gpio_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  abortIn,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctlStrobes_t           ctl
);

  logic [SYNC_STAGES-1:0] syncQ;

  // Reset to "abort seen" so enables stay low until a clean abort-free view
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= abortIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], abortIn};
      end
    end
  endgenerate

  always_comb begin
    ctl.abortSync = syncQ[SYNC_STAGES-1];
    ctl.wrDir     = regWrEn && (regAddr == REG_DIR);
    ctl.wrData    = regWrEn && (regAddr == REG_DATA);
  end

  // R9
  stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[REG_ADDR_W-1] == 1'b1) |-> !(ctl.wrDir || ctl.wrData));

endmodule

// File: rtl/gpioDirDatapath.sv
module gpioDirDatapath
  import gpio_dir_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [NUM_PINS-1:0]   rdData,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe
);

  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] dataQ;
  logic [NUM_PINS-1:0] oeQ;

  // Stored words always take writes; abort only gates the enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      dataQ <= '0;
      oeQ   <= '0;
    end else begin
      if (ctl.wrDir)  dirQ  <= wrData;
      if (ctl.wrData) dataQ <= wrData;
      oeQ <= dirQ & {NUM_PINS{~ctl.abortSync}};
    end
  end

  always_comb begin
    case (rdAddr)
      REG_DIR:  rdData = dirQ;
      REG_DATA: rdData = dataQ;
      default:  rdData = '0;
    endcase
  end

  assign pinOut = dataQ;
  assign pinOe  = oeQ;

  // R4
  oe_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abortSync |=> (oeQ == '0));

  // R6
  oe_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.abortSync |=> (oeQ == $past(dirQ)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrDir |=> (dirQ == $past(wrData)));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrDir |=> $stable(dirQ));

  // R7
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrData |=> (dataQ == $past(wrData)));

endmodule

// File: rtl/gpioAbortDir.sv
module gpioAbortDir
  import gpio_dir_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_PINS-1:0]   regWrData,
  output logic [NUM_PINS-1:0]   regRdData,
  input  logic                  abortIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe
);

  ctlStrobes_t ctl;

  gpioDirCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .abortIn(abortIn),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .ctl    (ctl)
  );

  gpioDirDatapath #(
    .NUM_PINS(NUM_PINS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .wrData(regWrData),
    .rdAddr(regAddr),
    .rdData(regRdData),
    .pinOut(pinOut),
    .pinOe (pinOe)
  );

endmodule

// File: tb/gpioAbortDir_tb.sv
module gpioAbortDir_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       abortIn = 1'b0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpioAbortDir u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .abortIn(abortIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // {abort, isData, wdata, expOe, expOut}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 1'b1, 8'h3C, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'hFF, 8'h00, 8'h3C},
    {1'b1, 1'b1, 8'hC3, 8'h00, 8'hC3},
    {1'b0, 1'b0, 8'h0F, 8'h0F, 8'hC3},
    {1'b1, 1'b0, 8'hF0, 8'h00, 8'hC3},
    {1'b0, 1'b1, 8'h81, 8'hF0, 8'h81},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h81}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readAt(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] lastDir;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", pinOe, 8'h00);
    rstN = 1'b1;
    #1;
    chk("R1 oe after reset", pinOe, 8'h00);
    chk("R1 out after reset", pinOut, 8'h00);
    readAt(2'd0, rv); chk("R1 dir reads zero", rv, 8'h00);
    readAt(2'd1, rv); chk("R1 data reads zero", rv, 8'h00);
    repeat (4) step();

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      abortIn   = VEC[i][25];
      regAddr   = VEC[i][24] ? 2'd1 : 2'd0;
      regWrData = VEC[i][23:16];
      regWrEn   = 1'b1;
      step();
      regWrEn = 1'b0;
      repeat (4) step();
      chk("R3/R4/R6 table oe", pinOe, VEC[i][15:8]);
      chk("R7 table out", pinOut, VEC[i][7:0]);
      readAt(VEC[i][24] ? 2'd1 : 2'd0, rv);
      chk("R2/R8 table readback", rv, VEC[i][23:16]);
    end

    // R3 exact latency of a direction write
    regAddr = 2'd0; regWrData = 8'h5A; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
    chk("R3 oe old after first edge", pinOe, 8'h00);
    readAt(2'd0, rv); chk("R2 dir readback", rv, 8'h5A);
    step();
    chk("R3 oe new after second edge", pinOe, 8'h5A);

    // R4 abort assertion latency
    abortIn = 1'b1;
    step(); chk("R4 oe after edge 1", pinOe, 8'h5A);
    step(); chk("R4 oe after edge 2", pinOe, 8'h5A);
    step(); chk("R4 oe zero after edge 3", pinOe, 8'h00);

    // R5 writes during abort are stored, never drive
    lastDir = 8'h00;
    for (int i = 0; i < 6; i++) begin
      lastDir = 8'((i + 1) * 8'h33);
      regAddr = 2'd0; regWrData = lastDir; regWrEn = 1'b1;
      step();
      regWrEn = 1'b0;
      chk("R5 oe zero at write", pinOe, 8'h00);
      readAt(2'd0, rv); chk("R5 stored during abort", rv, lastDir);
      step();
      chk("R5 oe zero after write", pinOe, 8'h00);
    end

    // R6 release restores stored direction
    abortIn = 1'b0;
    step(); chk("R6 oe zero after edge 1", pinOe, 8'h00);
    step(); chk("R6 oe zero after edge 2", pinOe, 8'h00);
    step(); chk("R6 oe restored after edge 3", pinOe, lastDir);

    // Coincidence: write lands on the edge where synchronised abort rises
    regAddr = 2'd0; regWrData = 8'h00; regWrEn = 1'b1;
    step(); regWrEn = 1'b0;
    repeat (3) step();
    chk("R3 oe cleared", pinOe, 8'h00);
    abortIn = 1'b1;
    step();
    regWrData = 8'hFF; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R5 coincident write oe", pinOe, 8'h00);
      step();
    end
    abortIn = 1'b0;
    step(); step();
    chk("R6 coincident still zero", pinOe, 8'h00);
    step();
    chk("R6 coincident restored", pinOe, 8'hFF);

    // R9 stray addresses ignored; R8 reads zero there
    regAddr = 2'd1; regWrData = 8'h66; regWrEn = 1'b1;
    step(); regWrEn = 1'b0;
    regAddr = 2'd2; regWrData = 8'h00; regWrEn = 1'b1;
    step();
    regAddr = 2'd3; regWrData = 8'h11;
    step(); regWrEn = 1'b0;
    repeat (3) step();
    chk("R9 oe unchanged", pinOe, 8'hFF);
    chk("R9 out unchanged", pinOut, 8'h66);
    readAt(2'd0, rv); chk("R9 dir unchanged", rv, 8'hFF);
    readAt(2'd1, rv); chk("R9 data unchanged", rv, 8'h66);
    readAt(2'd2, rv); chk("R8 addr2 reads zero", rv, 8'h00);
    readAt(2'd3, rv); chk("R8 addr3 reads zero", rv, 8'h00);

    // R7 output value written during abort
    abortIn = 1'b1;
    repeat (3) step();
    regAddr = 2'd1; regWrData = 8'h24; regWrEn = 1'b1;
    step(); regWrEn = 1'b0;
    chk("R7 out during abort", pinOut, 8'h24);
    chk("R4 oe zero while out written", pinOe, 8'h00);

    // R1 reset mid-run clears everything
    rstN = 1'b0;
    #1;
    chk("R1 oe on reset", pinOe, 8'h00);
    chk("R1 out on reset", pinOut, 8'h00);
    readAt(2'd0, rv); chk("R1 dir on reset", rv, 8'h00);

    finishRun();
  end

endmodule